// File: doc/BRIEF.md
# Output Term Source Selector Latch

This block picks where a small group of output terms comes from and registers them before they leave. Four sources are available: the read data of an upstream FIFO, a straight copy of the raw input terms (the bypass path), and two test words that the host loads through a small register port. A host-programmed two-bit select field chooses among bypass, FIFO and test word A. A separate timing input, the override, then has the last say: while it is high the terms come from test word B, whatever the select field holds.

The chosen value is captured in an output register on the rising edge of the tick clock. It is captured only in ticks where read enable is high, so the terms change at one fixed phase. This holds for every source, test words included, so a test run has the same output timing as normal running. The host reads back the select field and both test words through the same port, one cycle after it presents the address.

Top module: `term_source_latch`

## Requirements
- R1: After reset the output terms, both test words and the select field are all zero (select 00 means bypass).
- R2: With select 00 and the override low, an edge with read enable high loads the bypass input terms into the outputs.
- R3: With select 01 and the override low, an edge with read enable high loads the FIFO read terms into the outputs.
- R4: With select 10 and the override low, an edge with read enable high loads test word A into the outputs, and the FIFO and bypass inputs have no effect.
- R5: With select 11 and the override low, an edge with read enable high loads all-zero terms.
- R6: With the override high, an edge with read enable high loads test word B, whatever the select field holds.
- R7: On an edge with read enable low the outputs keep their value, whatever the sources, select field or override do.
- R8: Host address 0 holds the select field in bits 1:0, address 1 holds test word A in bits 3:0, and address 2 holds test word B in bits 3:0. A write takes effect at the clock edge where host_we is high. Read data is registered: it reflects the address presented at the previous edge. Unused bits read as zero, and address 3 reads as zero.
- R9: Host write bits above the width of a field are dropped. Writing 0xFA to test word A reads back 0x0A.
- R10: A write to address 3 changes none of the select field, test word A or test word B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read enable; qualifies the output register load |
| force_b | input | 1 | Override; selects test word B when high |
| fifo_terms | input | TERMS (4) | FIFO read data terms |
| bypass_terms | input | TERMS (4) | Raw input terms for the bypass path |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Host register address |
| host_wdata | input | DATA_W (8) | Host write data |
| host_rdata | output | DATA_W (8) | Registered host read data |
| out_terms | output | TERMS (4) | Registered output terms |

## Verification
The bench builds the block with the default four terms and an eight-bit host word. This leaves four unused upper bits in every host write, which is what makes the dropped-bit case of R9 observable. The scoreboard predicts the output for every tick from the select, test words and override as they stand before that edge. This makes the one-edge gap between a host write and its effect on the selection visible. Hold ticks are interleaved with changing sources to catch a latch that ignores read enable.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  typedef enum logic [1:0] {
    SRC_BYPASS = 2'b00,
    SRC_FIFO   = 2'b01,
    SRC_TEST_A = 2'b10,
    SRC_NONE   = 2'b11
  } src_sel_e;

  localparam int HOST_ADDR_W = 2;
  localparam logic [HOST_ADDR_W-1:0] ADDR_SEL    = 2'd0;
  localparam logic [HOST_ADDR_W-1:0] ADDR_TEST_A = 2'd1;
  localparam logic [HOST_ADDR_W-1:0] ADDR_TEST_B = 2'd2;
endpackage

// File: rtl/tsl_host_regs.sv
module tsl_host_regs
  import tsl_pkg::*;
#(
  parameter int TERMS  = 4,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [HOST_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rdata,
  output src_sel_e               sel,
  output logic [TERMS-1:0]       test_a,
  output logic [TERMS-1:0]       test_b
);
  localparam int SEL_W = $bits(src_sel_e);

  logic [DATA_W-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel    <= SRC_BYPASS;
      test_a <= '0;
      test_b <= '0;
    end else if (we) begin
      case (addr)
        ADDR_SEL:    sel    <= src_sel_e'(wdata[SEL_W-1:0]);
        ADDR_TEST_A: test_a <= wdata[TERMS-1:0];
        ADDR_TEST_B: test_b <= wdata[TERMS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr)
      ADDR_SEL:    rd_next[SEL_W-1:0] = sel;
      ADDR_TEST_A: rd_next[TERMS-1:0] = test_a;
      ADDR_TEST_B: rd_next[TERMS-1:0] = test_b;
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  // R10: the spare address leaves all fields untouched
  assert_spare_addr_R10: assert property (@(posedge clk) disable iff (rst)
    (we && addr == 2'd3) |=> ($stable(sel) && $stable(test_a) && $stable(test_b)));

  // R9: a test word keeps only its own width of the written data
  assert_trunc_write_R9: assert property (@(posedge clk) disable iff (rst)
    (we && addr == ADDR_TEST_A) |=> (test_a == $past(wdata[TERMS-1:0])));
endmodule

// File: rtl/tsl_src_mux.sv
module tsl_src_mux
  import tsl_pkg::*;
#(
  parameter int TERMS = 4
) (
  input  src_sel_e         sel,
  input  logic             force_b,
  input  logic [TERMS-1:0] fifo_terms,
  input  logic [TERMS-1:0] bypass_terms,
  input  logic [TERMS-1:0] test_a,
  input  logic [TERMS-1:0] test_b,
  output logic [TERMS-1:0] picked
);
  logic [TERMS-1:0] first_level;

  always_comb begin
    case (sel)
      SRC_BYPASS: first_level = bypass_terms;
      SRC_FIFO:   first_level = fifo_terms;
      SRC_TEST_A: first_level = test_a;
      default:    first_level = '0;
    endcase
  end

  assign picked = force_b ? test_b : first_level;
endmodule

// File: rtl/tsl_out_latch.sv
module tsl_out_latch #(
  parameter int TERMS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [TERMS-1:0] d,
  output logic [TERMS-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  // R7: no load, no change
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
endmodule

// File: rtl/term_source_latch.sv
module term_source_latch
  import tsl_pkg::*;
#(
  parameter int TERMS  = 4,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_en,
  input  logic                   force_b,
  input  logic [TERMS-1:0]       fifo_terms,
  input  logic [TERMS-1:0]       bypass_terms,
  input  logic                   host_we,
  input  logic [HOST_ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0]      host_wdata,
  output logic [DATA_W-1:0]      host_rdata,
  output logic [TERMS-1:0]       out_terms
);
  src_sel_e         sel;
  logic [TERMS-1:0] test_a;
  logic [TERMS-1:0] test_b;
  logic [TERMS-1:0] picked;

  tsl_host_regs #(.TERMS(TERMS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we(host_we), .addr(host_addr), .wdata(host_wdata),
    .rdata(host_rdata), .sel(sel), .test_a(test_a), .test_b(test_b)
  );

  tsl_src_mux #(.TERMS(TERMS)) u_mux (
    .sel(sel), .force_b(force_b), .fifo_terms(fifo_terms),
    .bypass_terms(bypass_terms), .test_a(test_a), .test_b(test_b),
    .picked(picked)
  );

  tsl_out_latch #(.TERMS(TERMS)) u_latch (
    .clk(clk), .rst(rst), .load(rd_en), .d(picked), .q(out_terms)
  );

  // R6: override wins on a loading edge
  assert_override_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && force_b) |=> (out_terms == $past(test_b)));

  // R5: undefined select code yields zero terms
  assert_zero_code_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !force_b && sel == SRC_NONE) |=> (out_terms == '0));

  // R4: test word A path
  assert_test_a_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !force_b && sel == SRC_TEST_A) |=> (out_terms == $past(test_a)));

  // R3: FIFO path
  assert_fifo_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !force_b && sel == SRC_FIFO) |=> (out_terms == $past(fifo_terms)));
endmodule

// File: tb/term_source_latch_test.sv
module term_source_latch_test;
  localparam int TERMS  = 4;
  localparam int DATA_W = 8;

  typedef struct {
    logic [TERMS-1:0] val;
    string            req;
  } exp_t;

  logic clk = 1'b0;
  logic rst, rd_en, force_b, host_we;
  logic [TERMS-1:0]  fifo_terms, bypass_terms;
  logic [1:0]        host_addr;
  logic [DATA_W-1:0] host_wdata;
  logic [DATA_W-1:0] host_rdata;
  logic [TERMS-1:0]  out_terms;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t q[$];

  logic [1:0]       m_sel;
  logic [TERMS-1:0] m_a, m_b, m_out;

  always #5 clk = ~clk;

  term_source_latch #(.TERMS(TERMS), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .force_b(force_b),
    .fifo_terms(fifo_terms), .bypass_terms(bypass_terms),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .out_terms(out_terms)
  );

  // monitor: compare outputs just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (out_terms !== e.val) begin
          errors++;
          $display("FAIL %s out_terms actual %h expected %h", e.req, out_terms, e.val);
        end
      end
    end
  end

  // driver: one tick of stimulus, prediction pushed to the scoreboard
  task automatic step(input logic rd, input logic fb, input logic [TERMS-1:0] ff,
                      input logic [TERMS-1:0] bp, input logic we, input logic [1:0] ad,
                      input logic [DATA_W-1:0] wd, input string req);
    exp_t e;
    @(negedge clk);
    rd_en = rd; force_b = fb; fifo_terms = ff; bypass_terms = bp;
    host_we = we; host_addr = ad; host_wdata = wd;
    if (rd) begin
      if (fb) m_out = m_b;
      else case (m_sel)
        2'b00: m_out = bp;
        2'b01: m_out = ff;
        2'b10: m_out = m_a;
        default: m_out = '0;
      endcase
    end
    e.val = m_out;
    e.req = rd ? req : "R7";
    q.push_back(e);
    if (we) case (ad)
      2'd0: m_sel = wd[1:0];
      2'd1: m_a = wd[TERMS-1:0];
      2'd2: m_b = wd[TERMS-1:0];
      default: ;
    endcase
  endtask

  task automatic wr(input logic [1:0] ad, input logic [DATA_W-1:0] wd);
    step(1'b0, 1'b0, 4'h0, 4'h0, 1'b1, ad, wd, "R7");
  endtask

  task automatic rd_chk(input logic [1:0] ad, input logic [DATA_W-1:0] exp, input string req);
    step(1'b0, 1'b0, 4'h0, 4'h0, 1'b0, ad, '0, "R7");
    @(posedge clk);
    #1;
    checks++;
    if (host_rdata !== exp) begin
      errors++;
      $display("FAIL %s host_rdata addr %0d actual %h expected %h", req, ad, host_rdata, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; rd_en = 0; force_b = 0; host_we = 0; host_addr = 0;
    host_wdata = 0; fifo_terms = 0; bypass_terms = 0;
    m_sel = 0; m_a = 0; m_b = 0; m_out = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (out_terms !== '0) begin
      errors++;
      $display("FAIL R1 out_terms actual %h expected 0", out_terms);
    end
    rd_chk(2'd0, 8'h00, "R1");
    rd_chk(2'd1, 8'h00, "R1");
    rd_chk(2'd2, 8'h00, "R1");

    // host port: field placement, truncation, spare address
    wr(2'd1, 8'hFA);
    rd_chk(2'd1, 8'h0A, "R9");
    wr(2'd2, 8'h35);
    rd_chk(2'd2, 8'h05, "R8");
    wr(2'd3, 8'hFF);
    rd_chk(2'd0, 8'h00, "R10");
    rd_chk(2'd1, 8'h0A, "R10");
    rd_chk(2'd2, 8'h05, "R10");
    rd_chk(2'd3, 8'h00, "R8");

    // bypass path (select left at reset value)
    step(1, 0, 4'hC, 4'h3, 0, 0, 0, "R2");
    step(1, 0, 4'h1, 4'h9, 0, 0, 0, "R2");
    step(0, 0, 4'h7, 4'hF, 0, 0, 0, "R7");
    step(0, 1, 4'h7, 4'h0, 0, 0, 0, "R7");

    // FIFO path
    wr(2'd0, 8'hFD);
    rd_chk(2'd0, 8'h01, "R8");
    step(1, 0, 4'h6, 4'h1, 0, 0, 0, "R3");
    step(1, 0, 4'hE, 4'h2, 0, 0, 0, "R3");

    // write and load in the same tick: old select still applies
    step(1, 0, 4'h4, 4'hB, 1, 2'd0, 8'h02, "R8");
    step(1, 0, 4'h5, 4'hD, 0, 0, 0, "R4");
    step(1, 0, 4'hF, 4'hF, 0, 0, 0, "R4");

    // undefined code
    wr(2'd0, 8'h03);
    step(1, 0, 4'hF, 4'hF, 0, 0, 0, "R5");

    // override across select values
    step(1, 1, 4'hF, 4'hF, 0, 0, 0, "R6");
    wr(2'd0, 8'h00);
    step(1, 1, 4'hA, 4'hC, 0, 0, 0, "R6");
    wr(2'd2, 8'h0E);
    step(1, 1, 4'h1, 4'h2, 0, 0, 0, "R6");
    step(1, 0, 4'h1, 4'h2, 0, 0, 0, "R2");
    step(0, 1, 4'h9, 4'h9, 0, 0, 0, "R7");

    step(0, 0, 0, 0, 0, 0, 0, "R7");
    repeat (2) @(posedge clk);
    #3;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule